// File: doc/BRIEF.md
# Bidirectional On-the-Fly AES-128 Round-Key Sequencer

This block delivers AES-128 round keys one at a time to a cipher datapath. It holds a single 128-bit working key and replaces it with the neighbouring round key on each step, so all eleven keys of a schedule can be reached without keeping a table of 1408 bits. In encrypt mode it starts from the cipher key and walks forward, from round 0 to round 10. In decrypt mode it first runs ten forward steps by itself to reach the last round key, then walks backward from round 10 to round 0 on request.

Both directions share one 32-bit word substitution, built from four byte substitutions, and one round-constant generator. A forward step derives the new first word from the old last word. A backward step first rebuilds the old last word from the XOR of the two top words of the current key, and then feeds that word into the same substitution to undo the first-word update.

Top module: `kx_top`

## Requirements
- R1: While reset is held and after its release, `rkey_o` is all zeros, `round_o` is 0 and `busy_o` is 0.
- R2: One cycle after `load_i` with `dec_i`=0, `rkey_o` equals `key_i`, `round_o` is 0 and `busy_o` is 0.
- R3: In encrypt mode, when `step_i` is high and `round_o` is below 10, the next cycle shows the next AES-128 round key and `round_o`+1. Word 0 is bits [127:96]. Rotation moves the top byte of word 3 to the bottom. The round constant is XORed into bits [127:120].
- R4: The round constant for round r (1 to 10) is 01,02,04,08,10,20,40,80,1B,36 in hex, which is doubling modulo x^8+x^4+x^3+x+1.
- R5: In encrypt mode at round 10, `step_i` is ignored: the key and round are unchanged.
- R6: After `load_i` with `dec_i`=1, `busy_o` is high for exactly ten cycles while `round_o` counts up 1 to 10. When it falls, `rkey_o` is the round-10 key of `key_i`.
- R7: While `busy_o` is high, `step_i` has no effect on the sequence of R6.
- R8: In decrypt mode with `busy_o` low and `round_o` above 0, `step_i` gives the previous round key and `round_o`-1 in the next cycle. The backward walk reproduces every forward key.
- R9: In decrypt mode at round 0, `step_i` is ignored.
- R10: `load_i` takes priority over `step_i` in the same cycle, and over a precompute in progress, which restarts.
- R11: The mode is taken from `dec_i` only on `load_i`. `dec_i` has no effect at other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_i | input | 128 | Cipher key captured on load |
| load_i | input | 1 | Capture key and mode |
| dec_i | input | 1 | Mode at load: 1 decrypt, 0 encrypt |
| step_i | input | 1 | Advance one round in the current direction |
| rkey_o | output | 128 | Current round key |
| round_o | output | 4 | Index of the current round key |
| busy_o | output | 1 | Final-key precompute in progress |

## Verification
A load can coincide with a step, and a new load can arrive during the automatic ten-step precompute. The bench provokes both cases. It raises `step_i` in the same cycle as a load and expects the loaded key at round 0. It also reloads four cycles into a precompute and expects a fresh run of exactly ten busy cycles that ends on the reloaded key's round-10 value. Steps held high throughout the precompute must not change its length or its result.

// File: rtl/kx_pkg.sv
package kx_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int WORDS  = 4;
  localparam int KEY_W  = WORD_W * WORDS;

  function automatic logic [7:0] xtime(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = '0;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // a^254 = a^-1, zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    logic [7:0] e;
    r = 8'h01;
    p = a;
    e = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] x;
    logic [7:0] y;
    x = gf_inv(a);
    for (int i = 0; i < 8; i++)
      y[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
    return y ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon(input int unsigned r);
    logic [7:0] v;
    v = 8'h01;
    for (int k = 1; k < 32; k++)
      if (k < r) v = xtime(v);
    return v;
  endfunction
endpackage

// File: rtl/kx_sub_word.sv
module kx_sub_word
  import kx_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic [BYTES*BYTE_W-1:0] word_i,
  output logic [BYTES*BYTE_W-1:0] word_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign word_o[b*BYTE_W +: BYTE_W] = sbox(word_i[b*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/kx_round_step.sv
module kx_round_step
  import kx_pkg::*;
#(
  parameter int NR = 10,
  localparam int RW = $clog2(NR + 1)
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [RW-1:0]    rnd_i,
  input  logic             back_i,
  output logic [KEY_W-1:0] nxt_o
);
  logic [WORD_W-1:0] w [WORDS];
  logic [WORD_W-1:0] n [WORDS];
  logic [WORD_W-1:0] sub_in, sub_rot, sub_out;
  logic [7:0]        rc;

  for (genvar i = 0; i < WORDS; i++) begin : g_split
    assign w[i] = key_i[KEY_W-1-i*WORD_W -: WORD_W];
    assign nxt_o[KEY_W-1-i*WORD_W -: WORD_W] = n[i];
  end

  // shared substitution: input is the older key's last word in both directions
  assign sub_in  = back_i ? (w[3] ^ w[2]) : w[3];
  assign sub_rot = {sub_in[WORD_W-BYTE_W-1:0], sub_in[WORD_W-1 -: BYTE_W]};

  kx_sub_word #(.BYTES(WORDS)) u_sub (
    .word_i (sub_rot),
    .word_o (sub_out)
  );

  assign rc = back_i ? rcon(32'(rnd_i)) : rcon(32'(rnd_i) + 1);

  always_comb begin
    if (back_i) begin
      n[3] = w[3] ^ w[2];
      n[2] = w[2] ^ w[1];
      n[1] = w[1] ^ w[0];
      n[0] = w[0] ^ sub_out ^ {rc, 24'h0};
    end else begin
      n[0] = w[0] ^ sub_out ^ {rc, 24'h0};
      n[1] = w[1] ^ n[0];
      n[2] = w[2] ^ n[1];
      n[3] = w[3] ^ n[2];
    end
  end
endmodule

// File: rtl/kx_ctrl.sv
module kx_ctrl #(
  parameter int NR = 10,
  localparam int RW = $clog2(NR + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          dec_i,
  input  logic          step_i,
  output logic          upd_o,
  output logic          back_o,
  output logic [RW-1:0] rnd_o,
  output logic          busy_o,
  output logic          dec_o
);
  localparam logic [RW-1:0] LAST = RW'(NR);

  logic [RW-1:0] rnd_q;
  logic          busy_q, dec_q;
  logic          at_last, at_first, adv, ret;

  assign at_last  = (rnd_q == LAST);
  assign at_first = (rnd_q == '0);
  assign adv = !load_i && (busy_q || (!dec_q && step_i && !at_last));
  assign ret = !load_i && !busy_q && dec_q && step_i && !at_first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q  <= '0;
      busy_q <= 1'b0;
      dec_q  <= 1'b0;
    end else if (load_i) begin
      rnd_q  <= '0;
      busy_q <= dec_i;
      dec_q  <= dec_i;
    end else if (adv) begin
      rnd_q <= rnd_q + 1'b1;
      if (busy_q && (rnd_q + 1'b1 == LAST)) busy_q <= 1'b0;
    end else if (ret) begin
      rnd_q <= rnd_q - 1'b1;
    end
  end

  assign upd_o  = adv || ret;
  assign back_o = ret;
  assign rnd_o  = rnd_q;
  assign busy_o = busy_q;
  assign dec_o  = dec_q;

  p_round_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_q <= LAST);
  p_busy_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> at_last);
  p_busy_ignores_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !load_i |=> rnd_q == $past(rnd_q) + 1'b1);
  p_enc_fwd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !busy_q && !dec_q && step_i && !at_last |=> rnd_q == $past(rnd_q) + 1'b1);
  p_dec_back_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !busy_q && dec_q && step_i && !at_first |=> rnd_q == $past(rnd_q) - 1'b1);
  p_load_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rnd_q == '0 && busy_q == $past(dec_i));
  p_mode_latched_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(dec_q));
endmodule

// File: rtl/kx_top.sv
module kx_top
  import kx_pkg::*;
#(
  parameter int NR = 10,
  localparam int RW = $clog2(NR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic             step_i,
  output logic [KEY_W-1:0] rkey_o,
  output logic [RW-1:0]    round_o,
  output logic             busy_o
);
  logic [KEY_W-1:0] key_q, nxt;
  logic             upd, back, dec_mode;

  kx_ctrl #(.NR(NR)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .dec_i  (dec_i),
    .step_i (step_i),
    .upd_o  (upd),
    .back_o (back),
    .rnd_o  (round_o),
    .busy_o (busy_o),
    .dec_o  (dec_mode)
  );

  kx_round_step #(.NR(NR)) u_step (
    .key_i  (key_q),
    .rnd_i  (round_o),
    .back_i (back),
    .nxt_o  (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (load_i) key_q <= key_i;
    else if (upd)    key_q <= nxt;
  end

  assign rkey_o = key_q;

  p_load_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rkey_o == $past(key_i));
  p_enc_end_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !busy_o && !dec_mode && round_o == RW'(NR) |=> $stable(rkey_o));
  p_dec_start_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !busy_o && dec_mode && round_o == '0 |=> $stable(rkey_o));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !busy_o && !step_i |=> $stable(rkey_o) && $stable(round_o));
endmodule

// File: tb/sim_kx_top.sv
`timescale 1ns/1ps
module sim_kx_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] key = '0;
  logic         load = 1'b0, dec = 1'b0, step = 1'b0;
  logic [127:0] rkey;
  logic [3:0]   round;
  logic         busy;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  localparam logic [127:0] RK [11] = '{
    128'h2b7e151628aed2a6abf7158809cf4f3c,
    128'ha0fafe1788542cb123a339392a6c7605,
    128'hf2c295f27a96b9435935807a7359f67f,
    128'h3d80477d4716fe3e1e237e446d7a883b,
    128'hef44a541a8525b7fb671253bdb0bad00,
    128'hd4d1c6f87c839d87caf2b8bc11f915bc,
    128'h6d88a37a110b3efddbf98641ca0093fd,
    128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
    128'head27321b58dbad2312bf5607f8d292f,
    128'hac7766f319fadc2128d12941575c006e,
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6
  };

  logic [127:0] zfwd [11];

  always #2.5 clk = ~clk;

  kx_top u0 (
    .clk_i (clk), .rst_ni (rst_n), .key_i (key), .load_i (load),
    .dec_i (dec), .step_i (step), .rkey_o (rkey), .round_o (round), .busy_o (busy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [127:0] k, input logic d, input logic s);
    key = k; dec = d; load = 1'b1; step = s;
    tick();
    load = 1'b0; step = 1'b0;
  endtask

  task automatic wait_busy(input string req, input int exp_cycles, input logic hold_step);
    int cnt = 0;
    step = hold_step;
    while (busy && cnt < 40) begin
      tick();
      cnt++;
      if (cnt == 1) chk({req, " round during precompute"}, 128'(round), 128'd1);
      dec = ~dec;
    end
    step = 1'b0;
    chk({req, " busy cycles"}, 128'(cnt), 128'(exp_cycles));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset key", rkey, '0);
    chk("R1 reset round", 128'(round), 0);
    chk("R1 reset busy", 128'(busy), 0);
    #10 rst_n = 1'b1;
    tick();
    chk("R1 post-reset key", rkey, '0);

    // R10: step raised together with load
    do_load(RK[0], 1'b0, 1'b1);
    chk("R2 R10 loaded key", rkey, RK[0]);
    chk("R2 R10 round 0", 128'(round), 0);
    chk("R2 busy low", 128'(busy), 0);

    // R3/R4 forward walk through the table
    for (int i = 1; i <= 10; i++) begin
      step = 1'b1; dec = 1'b1;  // R11: dec_i ignored between loads
      tick();
      step = 1'b0;
      chk($sformatf("R3 R4 R11 fwd key %0d", i), rkey, RK[i]);
      chk($sformatf("R3 fwd round %0d", i), 128'(round), 128'(i));
    end
    step = 1'b1; tick(); step = 1'b0;
    chk("R5 key held at end", rkey, RK[10]);
    chk("R5 round held at end", 128'(round), 10);

    // R6/R7 precompute with step held high
    do_load(RK[0], 1'b1, 1'b0);
    chk("R6 busy after load", 128'(busy), 1);
    wait_busy("R6 R7", 10, 1'b1);
    chk("R6 final key", rkey, RK[10]);
    chk("R6 final round", 128'(round), 10);

    // R8 backward walk
    for (int i = 9; i >= 0; i--) begin
      step = 1'b1; dec = 1'b0;
      tick();
      step = 1'b0;
      chk($sformatf("R8 R11 back key %0d", i), rkey, RK[i]);
      chk($sformatf("R8 back round %0d", i), 128'(round), 128'(i));
    end
    step = 1'b1; tick(); step = 1'b0;
    chk("R9 key held at start", rkey, RK[0]);
    chk("R9 round held at start", 128'(round), 0);

    // R10 reload during precompute
    do_load('0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) tick();
    do_load(RK[0], 1'b1, 1'b0);
    chk("R10 round after reload", 128'(round), 0);
    wait_busy("R10 reload", 10, 1'b0);
    chk("R10 reload final key", rkey, RK[10]);

    // all-zero key: forward then backward
    do_load('0, 1'b0, 1'b0);
    zfwd[0] = rkey;
    for (int i = 1; i <= 10; i++) begin
      step = 1'b1; tick(); step = 1'b0;
      zfwd[i] = rkey;
    end
    chk("R3 R4 zero key rk1", zfwd[1], 128'h62636363626363636263636362636363);
    chk("R3 R4 zero key rk10", zfwd[10], 128'hb4ef5bcb3e92e21123e951cf6f8f188e);
    do_load('0, 1'b1, 1'b0);
    wait_busy("R6 zero", 10, 1'b0);
    chk("R6 zero final key", rkey, zfwd[10]);
    for (int i = 9; i >= 0; i--) begin
      step = 1'b1; tick(); step = 1'b0;
      chk($sformatf("R8 zero back key %0d", i), rkey, zfwd[i]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule